// File: doc/BRIEF.md
# Single-wire bus transceiver mode controller

This block is the digital control core of a single-wire CAN physical-layer transceiver. It turns two mode pins into one of four operating states (sleep, high-voltage wake-up transmit, high-speed transmit, waveshaped normal transmit). It also controls the bus driver stage: whether the driver is powered, whether it asserts the bus, and whether it uses the raised voltage or the unshaped fast edge. The received-data output is built from a digitised bus comparator.

While asleep, the block watches a comparator flag for the raised wake voltage on the bus. A wake raises the regulator-enable output, so the host can power up, and a hold timer starts. The host keeps the node awake by moving the mode pins to any non-sleep value. If the pins are still at sleep when the timer expires, the regulator enable drops, even when the bus is still at the wake voltage. While asleep, the received-data output stays released except inside a wake window.

The fault flags for undervoltage, thermal shutdown and lost module ground act as interlocks. Every timer counts a 500 kHz reference tick that arrives as a one-cycle enable on the system clock. The wake flag and the fault flags pass through two-stage synchronisers before any logic uses them.

Top module: `swbus_mode_ctrl`

## Requirements
- R1: The mode pins decode as {modeSel0, modeSel1}: 00 sleep, 01 wake-up transmit (drvHighV=1), 10 fast transmit (drvNoShape=1), 11 normal transmit (both selects 0). In sleep the bus is never asserted. Selects and drive update one clock after the pins change.
- R2: In any non-sleep mode, txData=0 sets busDrive=1 (dominant) and txData=1 clears it (recessive), one clock later.
- R3: In a non-sleep mode, rxOut is the inverse of busDom (0 for a dominant bus), one clock later.
- R4: After reset: busDrive=0, drvEn=0, drvHighV=0, drvNoShape=0, rxOut=1, regEn=0, loadSwOn=1.
- R5: In sleep with no wake window open, rxOut stays 1 whatever busDom is.
- R6: A rising wake flag seen in sleep raises regEn within three clocks and opens the receive window, so that rxOut follows busDom.
- R7: regEn stays high for HOLD_TICKS ticks after a wake detection. It then falls with the pins at sleep, and the receive window closes, even if the wake level is still present.
- R8: Each new rising edge of the wake flag in sleep restarts the full hold time.
- R9: After the wake level goes away in sleep, rxOut keeps following busDom for RX_TAIL_TICKS ticks and is then released.
- R10: Any non-sleep mode holds regEn high and cancels the hold timer. Returning the pins to sleep therefore drops regEn immediately, and wake edges seen while awake start no hold.
- R11: drvEn stays high for DRV_TAIL_TICKS ticks after busDrive returns to 0, then falls.
- R12: Undervoltage forces busDrive=0, drvEn=0 and rxOut=1.
- R13: Thermal shutdown forces busDrive=0 and drvEn=0 and leaves rxOut following the bus.
- R14: loadSwOn is 1 unless loss of ground is flagged, in which case it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 500 kHz timing enable |
| txData | input | 1 | Transmit data, 0 asserts the bus |
| modeSel0 | input | 1 | Mode pin, upper bit of the mode code |
| modeSel1 | input | 1 | Mode pin, lower bit of the mode code |
| busDom | input | 1 | Comparator: bus at a dominant level |
| busWake | input | 1 | Comparator: bus at the wake voltage |
| underVolt | input | 1 | Undervoltage flag |
| overTemp | input | 1 | Thermal shutdown flag |
| gndLoss | input | 1 | Loss of module ground flag |
| busDrive | output | 1 | Driver asserts the dominant level |
| drvEn | output | 1 | Driver stage enabled |
| drvHighV | output | 1 | Driver uses the raised wake voltage |
| drvNoShape | output | 1 | Driver bypasses waveshaping |
| rxOut | output | 1 | Received data, 1 = released |
| regEn | output | 1 | Regulator enable |
| loadSwOn | output | 1 | Load-resistor switch closed |

## Verification
The hardest case to reach is a hold expiry that happens while the wake level is still on the bus. The regulator enable must drop and the receive window must close even though the comparator still reports a wake. To reach it, the bench holds the wake flag high across the whole timeout, with a short hold parameter and a tick every four clocks. The restart case is similar: a second wake edge is placed partway through the first hold, and the bench checks that regEn is still high past the point where the first hold would have expired.

// File: rtl/swbus_pkg.sv
package swbus_pkg;
  // Encoding is {modeSel0, modeSel1}
  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'b00,
    MODE_WAKEUP = 2'b01,
    MODE_FAST   = 2'b10,
    MODE_NORMAL = 2'b11
  } mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic awake;
    logic hvSel;
    logic fastSel;
    logic rxOpen;
    logic uvBlk;
    logic otBlk;
    logic gndOpen;
  } ctl_s;
endpackage

// File: rtl/swbus_sync.sv
module swbus_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/swbus_ctrl.sv
module swbus_ctrl
  import swbus_pkg::*;
#(
  parameter int HOLD_TICKS    = 250000,
  parameter int RX_TAIL_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic modeSel0,
  input  logic modeSel1,
  input  logic wakeS,
  input  logic uvS,
  input  logic otS,
  input  logic gndS,
  output ctl_s ctl,
  output logic regEn
);
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
  localparam int RXT_W  = $clog2(RX_TAIL_TICKS + 1);

  mode_e mode;
  logic awake, wakePrev, wakeRise, wakeFall, holdActive;
  logic [HOLD_W-1:0] holdCnt;
  logic [RXT_W-1:0]  rxTail;

  assign mode     = mode_e'({modeSel0, modeSel1});
  assign awake    = (mode != MODE_SLEEP);
  assign wakeRise = wakeS & ~wakePrev;
  assign wakeFall = ~wakeS & wakePrev;
  assign holdActive = (holdCnt != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wakePrev <= 1'b0;
    else        wakePrev <= wakeS;

  // Hold timer: loaded on each wake edge in sleep, cleared by the host
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               holdCnt <= '0;
    else if (awake)           holdCnt <= '0;
    else if (wakeRise)        holdCnt <= HOLD_W'(HOLD_TICKS);
    else if (tick && holdActive) holdCnt <= holdCnt - 1'b1;

  // Short receive tail after the wake level leaves
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     rxTail <= '0;
    else if (awake)                 rxTail <= '0;
    else if (wakeFall)              rxTail <= RXT_W'(RX_TAIL_TICKS);
    else if (tick && rxTail != '0)  rxTail <= rxTail - 1'b1;

  assign regEn       = awake | holdActive;
  assign ctl.awake   = awake;
  assign ctl.hvSel   = (mode == MODE_WAKEUP);
  assign ctl.fastSel = (mode == MODE_FAST);
  assign ctl.rxOpen  = holdActive & (wakeS | wakePrev | (rxTail != '0));
  assign ctl.uvBlk   = uvS;
  assign ctl.otBlk   = otS;
  assign ctl.gndOpen = gndS;

  // R6
  wake_regen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wakeRise && !awake) |=> regEn);

  // R7
  hold_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && !wakeRise && tick && holdCnt == HOLD_W'(1)) |=> (!regEn || awake));

  // R10
  host_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(awake) |-> !regEn);
endmodule

// File: rtl/swbus_dpath.sv
module swbus_dpath
  import swbus_pkg::*;
#(
  parameter int DRV_TAIL_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic txData,
  input  logic busDom,
  input  ctl_s ctl,
  output logic busDrive,
  output logic drvEn,
  output logic drvHighV,
  output logic drvNoShape,
  output logic rxOut,
  output logic loadSwOn
);
  localparam int DT_W = $clog2(DRV_TAIL_TICKS + 1);

  logic [DT_W-1:0] tailCnt;
  logic driveNext, drvBlock, releaseNow, drvEnNext, rxNext;

  assign drvBlock   = ~ctl.awake | ctl.uvBlk | ctl.otBlk;
  assign driveNext  = ~drvBlock & ~txData;
  assign releaseNow = busDrive & ~driveNext;
  assign drvEnNext  = ~drvBlock & (driveNext | releaseNow | (tailCnt != '0));
  assign rxNext     = ctl.uvBlk ? 1'b1 :
                      (ctl.awake | ctl.rxOpen) ? ~busDom : 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      tailCnt <= '0;
    else if (drvBlock || driveNext)  tailCnt <= '0;
    else if (releaseNow)             tailCnt <= DT_W'(DRV_TAIL_TICKS);
    else if (tick && tailCnt != '0)  tailCnt <= tailCnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busDrive   <= 1'b0;
      drvEn      <= 1'b0;
      drvHighV   <= 1'b0;
      drvNoShape <= 1'b0;
      rxOut      <= 1'b1;
      loadSwOn   <= 1'b1;
    end else begin
      busDrive   <= driveNext;
      drvEn      <= drvEnNext;
      drvHighV   <= ctl.hvSel;
      drvNoShape <= ctl.fastSel;
      rxOut      <= rxNext;
      loadSwOn   <= ~ctl.gndOpen;
    end

  // R12
  uv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.uvBlk |=> (!busDrive && !drvEn && rxOut));

  // R13
  ot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.otBlk |=> (!busDrive && !drvEn));

  // R5
  sleep_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.awake && !ctl.rxOpen) |=> rxOut);

  // R11
  tail_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drvEn && !busDrive) |-> $past(drvEn));
endmodule

// File: rtl/swbus_mode_ctrl.sv
module swbus_mode_ctrl
  import swbus_pkg::*;
#(
  parameter int HOLD_TICKS     = 250000,
  parameter int RX_TAIL_TICKS  = 8,
  parameter int DRV_TAIL_TICKS = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic txData,
  input  logic modeSel0,
  input  logic modeSel1,
  input  logic busDom,
  input  logic busWake,
  input  logic underVolt,
  input  logic overTemp,
  input  logic gndLoss,
  output logic busDrive,
  output logic drvEn,
  output logic drvHighV,
  output logic drvNoShape,
  output logic rxOut,
  output logic regEn,
  output logic loadSwOn
);
  localparam int NFLAG = 4;

  logic [NFLAG-1:0] flagRaw, flagS;
  ctl_s ctl;

  assign flagRaw = {busWake, underVolt, overTemp, gndLoss};

  swbus_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(flagRaw), .q(flagS)
  );

  swbus_ctrl #(.HOLD_TICKS(HOLD_TICKS), .RX_TAIL_TICKS(RX_TAIL_TICKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .modeSel0(modeSel0), .modeSel1(modeSel1),
    .wakeS(flagS[3]), .uvS(flagS[2]), .otS(flagS[1]), .gndS(flagS[0]),
    .ctl(ctl), .regEn(regEn)
  );

  swbus_dpath #(.DRV_TAIL_TICKS(DRV_TAIL_TICKS)) u_dpath (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .txData(txData), .busDom(busDom), .ctl(ctl),
    .busDrive(busDrive), .drvEn(drvEn), .drvHighV(drvHighV),
    .drvNoShape(drvNoShape), .rxOut(rxOut), .loadSwOn(loadSwOn)
  );
endmodule

// File: tb/swbus_mode_ctrl_tb.sv
`timescale 1ns/1ps
module swbus_mode_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic txData = 1'b1, modeSel0 = 1'b0, modeSel1 = 1'b0;
  logic busDom = 1'b0, busWake = 1'b0;
  logic underVolt = 1'b0, overTemp = 1'b0, gndLoss = 1'b0;
  logic busDrive, drvEn, drvHighV, drvNoShape, rxOut, regEn, loadSwOn;
  int checks = 0, failures = 0;
  int tickDiv = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tickDiv <= (tickDiv == 3) ? 0 : tickDiv + 1;
    tick    <= (tickDiv == 3);
  end

  swbus_mode_ctrl #(.HOLD_TICKS(12), .RX_TAIL_TICKS(3), .DRV_TAIL_TICKS(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .txData(txData),
    .modeSel0(modeSel0), .modeSel1(modeSel1), .busDom(busDom), .busWake(busWake),
    .underVolt(underVolt), .overTemp(overTemp), .gndLoss(gndLoss),
    .busDrive(busDrive), .drvEn(drvEn), .drvHighV(drvHighV), .drvNoShape(drvNoShape),
    .rxOut(rxOut), .regEn(regEn), .loadSwOn(loadSwOn)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic setMode(input logic m0, input logic m1);
    modeSel0 = m0; modeSel1 = m1;
  endtask

  task automatic t_reset;
    chk("R4 rxOut", rxOut, 1'b1);
    chk("R4 regEn", regEn, 1'b0);
    chk("R4 busDrive", busDrive, 1'b0);
    chk("R4 drvEn", drvEn, 1'b0);
    chk("R4 drvHighV", drvHighV, 1'b0);
    chk("R4 drvNoShape", drvNoShape, 1'b0);
    chk("R4 loadSwOn", loadSwOn, 1'b1);
  endtask

  task automatic t_modes;
    txData = 1'b0;
    setMode(0, 0); cyc(1);
    chk("R1 sleep no drive", busDrive, 1'b0);
    setMode(0, 1); cyc(1);
    chk("R1 wakeup hv", drvHighV, 1'b1);
    chk("R1 wakeup shape", drvNoShape, 1'b0);
    chk("R2 wakeup drive", busDrive, 1'b1);
    setMode(1, 0); cyc(1);
    chk("R1 fast hv", drvHighV, 1'b0);
    chk("R1 fast noshape", drvNoShape, 1'b1);
    chk("R2 fast drive", busDrive, 1'b1);
    setMode(1, 1); cyc(1);
    chk("R1 normal hv", drvHighV, 1'b0);
    chk("R1 normal noshape", drvNoShape, 1'b0);
    chk("R2 normal drive", busDrive, 1'b1);
    txData = 1'b1; cyc(1);
    chk("R2 recessive", busDrive, 1'b0);
    // R11 tail after release
    chk("R11 tail on", drvEn, 1'b1);
    cyc(16);
    chk("R11 tail off", drvEn, 1'b0);
    busDom = 1'b1; cyc(1);
    chk("R3 rx dominant", rxOut, 1'b0);
    busDom = 1'b0; cyc(1);
    chk("R3 rx recessive", rxOut, 1'b1);
    setMode(0, 0); cyc(2);
  endtask

  task automatic t_sleepRx;
    busDom = 1'b1; cyc(3);
    chk("R5 sleep rx released", rxOut, 1'b1);
    busDom = 1'b0; cyc(1);
  endtask

  task automatic t_holdExpire;
    busWake = 1'b1; busDom = 1'b1; cyc(6);
    chk("R6 regEn raised", regEn, 1'b1);
    chk("R6 rx follows", rxOut, 1'b0);
    cyc(24);
    chk("R7 still held", regEn, 1'b1);
    cyc(40);
    chk("R7 regEn expired", regEn, 1'b0);
    chk("R7 rx closed", rxOut, 1'b1);
    busWake = 1'b0; busDom = 1'b0; cyc(24);
  endtask

  task automatic t_restart;
    busWake = 1'b1; cyc(4); busWake = 1'b0; cyc(26);
    busWake = 1'b1; cyc(4); busWake = 1'b0; cyc(36);
    chk("R8 restarted hold", regEn, 1'b1);
    cyc(40);
    chk("R8 restarted expiry", regEn, 1'b0);
  endtask

  task automatic t_rxTail;
    busWake = 1'b1; busDom = 1'b1; cyc(8);
    busWake = 1'b0; cyc(3);
    chk("R9 tail follows bus", rxOut, 1'b0);
    cyc(21);
    chk("R9 tail released", rxOut, 1'b1);
    busDom = 1'b0; cyc(60);
  endtask

  task automatic t_host;
    busWake = 1'b1; cyc(4); busWake = 1'b0; cyc(4);
    setMode(1, 1); cyc(60);
    chk("R10 host keeps regEn", regEn, 1'b1);
    busWake = 1'b1; cyc(4); busWake = 1'b0; cyc(4);
    setMode(0, 0); cyc(2);
    chk("R10 immediate release", regEn, 1'b0);
  endtask

  task automatic t_faults;
    setMode(1, 1); txData = 1'b0; busDom = 1'b1; cyc(2);
    underVolt = 1'b1; cyc(5);
    chk("R12 uv drive", busDrive, 1'b0);
    chk("R12 uv drvEn", drvEn, 1'b0);
    chk("R12 uv rx", rxOut, 1'b1);
    underVolt = 1'b0; cyc(5);
    chk("R12 uv clear drive", busDrive, 1'b1);
    overTemp = 1'b1; cyc(5);
    chk("R13 ot drive", busDrive, 1'b0);
    chk("R13 ot drvEn", drvEn, 1'b0);
    chk("R13 ot rx follows", rxOut, 1'b0);
    overTemp = 1'b0; gndLoss = 1'b1; cyc(5);
    chk("R14 load open", loadSwOn, 1'b0);
    gndLoss = 1'b0; cyc(5);
    chk("R14 load closed", loadSwOn, 1'b1);
    txData = 1'b1; busDom = 1'b0; setMode(0, 0); cyc(2);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_modes();
    t_sleepRx();
    t_holdExpire();
    t_restart();
    t_rxTail();
    t_host();
    t_faults();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule